// File: doc/BRIEF.md
# Timed FIFO Write Port

This block sits on the write side of a synchronous FIFO and turns a single write request into a bounded wait for free space. The client presents a data element together with a signed timeout, counted in clock cycles. If the FIFO has room, or gains room before the timeout runs out, the element is pushed and the request completes normally. If no room appears in time, the request completes with a full indication and the element is discarded. A zero timeout makes one attempt only, and any negative timeout means wait without limit.

Completion is reported with a one-cycle `done_o` pulse, and `full_o` is valid in the same cycle. With a zero timeout the block takes a new request on every clock, so it can be driven by a loop that issues one write per cycle. The FIFO storage and a simple read port are part of the block so that it can be exercised on its own. A read that frees a slot in the same cycle as a waiting write lets that write succeed at that edge.

Top module: `fifo_wr_timeout`

## Requirements
- R1: A request with timeout 0 is sampled at clock edge e0, and `done_o` is high in the cycle after e0. Back-to-back zero-timeout requests are accepted on consecutive clocks.
- R2: A request that finds free space at e0 pushes its element at e0 and completes in the cycle after e0 with `full_o` low. This holds for any timeout value.
- R3: A request with timeout T>0 that never sees free space makes T further attempts, at edges e1..eT. It then completes in the cycle after eT with `full_o` high.
- R4: When `full_o` is high with `done_o`, the element is not stored and `level_o` keeps its value.
- R5: A negative timeout, whatever its value, disables the limit. The request waits until space appears and then completes with `full_o` low.
- R6: `done_o` is high for one cycle per request. `busy_o` is high while a request waits. A `req_i` asserted while `busy_o` is high is ignored and stores nothing.
- R7: If `rd_en_i` removes an element at the same edge at which a write is waiting on a full FIFO, the write succeeds at that edge.
- R8: Elements leave in the order they were stored. `rd_data_o` shows the oldest element, `level_o` gives the count, and `empty_o` flags zero elements. `rd_en_i` on an empty FIFO is ignored.
- R9: Reset (`rst_ni` low) empties the FIFO, drops any waiting request, and clears `done_o`, `full_o` and `busy_o`.
- R10: If space appears at edge ek with 1<=k<=T, the waiting write completes in the cycle after ek with `full_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, taken when not busy |
| data_i | input | DATA_W | Element to store |
| timeout_i | input | TMO_W | Signed wait limit in cycles (0: single try, negative: unlimited) |
| busy_o | output | 1 | A request is waiting for space |
| done_o | output | 1 | One-cycle completion pulse |
| full_o | output | 1 | With done_o: no space was found, element dropped |
| rd_en_i | input | 1 | Remove the oldest element |
| rd_data_o | output | DATA_W | Oldest element |
| empty_o | output | 1 | FIFO holds no element |
| level_o | output | $clog2(DEPTH)+1 | Number of stored elements |

## Verification
The bench builds the block with DATA_W=8 and DEPTH=4, so the FIFO fills after four writes. This keeps the full condition cheap to reach and to hold. It sweeps every timeout from 0 to 6 against a FIFO that stays full. It also sweeps every release edge k within timeouts 1 to 5, which covers both the last-chance success and the expiry boundary. Several negative timeouts, including the most negative value, are checked for unlimited waiting. A reference queue in the bench checks the order of the stored data after every sweep.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wr_state_e;
endpackage

// File: rtl/fwt_fifo.sv
module fwt_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  level_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W:0]    wr_ptr_q, rd_ptr_q;
  logic              pop_fire, push_fire;

  // extra wrap bit separates full from empty
  assign empty_o = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[PTR_W] != rd_ptr_q[PTR_W]) &&
                   (wr_ptr_q[PTR_W-1:0] == rd_ptr_q[PTR_W-1:0]);
  assign pop_fire  = pop_i && !empty_o;
  assign push_fire = push_i && (!full_o || pop_fire);
  assign level_o   = CNT_W'(wr_ptr_q - rd_ptr_q);
  assign pop_data_o = mem_q[rd_ptr_q[PTR_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_fire) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_fire)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_fire) mem_q[wr_ptr_q[PTR_W-1:0]] <= push_data_i;
  end
endmodule

// File: rtl/fwt_timer.sv
module fwt_timer #(
  parameter int TMO_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMO_W-1:0] value_i,
  input  logic             dec_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             inf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      inf_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= value_i;
      inf_q <= value_i[TMO_W-1];  // any negative value: no limit
    end else if (dec_i && !inf_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // last attempt is the one taken when one tick remains
  assign expire_o = !inf_q && (cnt_q == TMO_W'(1));
endmodule

// File: rtl/fwt_wait_ctrl.sv
module fwt_wait_ctrl
  import fwt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TMO_W-1:0]  tmo_i,
  input  logic              space_i,
  input  logic              expire_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              load_o,
  output logic              dec_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              full_o
);
  wr_state_e         state_q, state_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              done_q, done_d, fail_q, fail_d;

  always_comb begin
    state_d     = state_q;
    hold_d      = hold_q;
    done_d      = 1'b0;
    fail_d      = 1'b0;
    push_o      = 1'b0;
    load_o      = 1'b0;
    dec_o       = 1'b0;
    push_data_o = (state_q == ST_WAIT) ? hold_q : data_i;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (space_i) begin
            push_o = 1'b1;
            done_d = 1'b1;
          end else if (tmo_i == '0) begin
            done_d = 1'b1;
            fail_d = 1'b1;
          end else begin
            state_d = ST_WAIT;
            load_o  = 1'b1;
            hold_d  = data_i;
          end
        end
      end
      ST_WAIT: begin
        if (space_i) begin
          push_o  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (expire_i) begin
          done_d  = 1'b1;
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          dec_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign busy_o = (state_q == ST_WAIT);
  assign done_o = done_q;
  assign full_o = fail_q;
endmodule

// File: rtl/fifo_wr_timeout.sv
module fifo_wr_timeout #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int TMO_W  = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TMO_W-1:0]  timeout_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              full_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  level_o
);
  logic              push, load, dec, expire, fifo_full, space;
  logic [DATA_W-1:0] push_data;

  // a read at the same edge frees the slot for the waiting write
  assign space = !fifo_full || rd_en_i;

  fwt_wait_ctrl #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .data_i     (data_i),
    .tmo_i      (timeout_i),
    .space_i    (space),
    .expire_i   (expire),
    .push_o     (push),
    .push_data_o(push_data),
    .load_o     (load),
    .dec_o      (dec),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .full_o     (full_o)
  );

  fwt_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .value_i (timeout_i),
    .dec_i   (dec),
    .expire_o(expire)
  );

  fwt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_data_i(push_data),
    .pop_i      (rd_en_i),
    .pop_data_o (rd_data_o),
    .full_o     (fifo_full),
    .empty_o    (empty_o),
    .level_o    (level_o)
  );
endmodule

// File: rtl/fwt_checker.sv
module fwt_checker #(
  parameter int DEPTH = 4,
  parameter int TMO_W = 32,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [TMO_W-1:0] timeout_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             full_o,
  input logic             rd_en_i,
  input logic             empty_o,
  input logic [CNT_W-1:0] level_o
);
  a_r1_zero_tmo_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && timeout_i == '0) |=> done_o);

  a_r4_fail_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && full_o) |-> ($past(level_o) == CNT_W'(DEPTH) && !$past(rd_en_i)));

  a_r4_fail_level_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && full_o) |-> (level_o == $past(level_o)));

  a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r7_read_frees_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_en_i) |=> (done_o && !full_o));

  a_r8_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CNT_W'(DEPTH));

  a_r8_empty_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (level_o == '0));
endmodule

bind fifo_wr_timeout fwt_checker #(.DEPTH(DEPTH), .TMO_W(TMO_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .timeout_i(timeout_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .full_o   (full_o),
  .rd_en_i  (rd_en_i),
  .empty_o  (empty_o),
  .level_o  (level_o)
);

// File: tb/fifo_wr_timeout_bench.sv
`timescale 1ns/1ps
module fifo_wr_timeout_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int TMO_W  = 32;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [TMO_W-1:0]  timeout_i = '0;
  logic              rd_en_i = 1'b0;
  logic              busy_o, done_o, full_o, empty_o;
  logic [DATA_W-1:0] rd_data_o;
  logic [CNT_W-1:0]  level_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] mq[$];

  always #2.5 clk = ~clk;

  fifo_wr_timeout #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TMO_W(TMO_W)) u_fifo_wr_timeout (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .data_i(data_i), .timeout_i(timeout_i),
    .busy_o(busy_o), .done_o(done_o), .full_o(full_o), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .empty_o(empty_o), .level_o(level_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // starts and ends at a negedge; rel_k: edge index whose read frees space (0: none)
  task automatic do_write(input logic [7:0] d, input int tmo, input int rel_k,
                          input bit noise, output int lat, output bit fl);
    int n = 0;
    req_i = 1'b1; data_i = d; timeout_i = tmo;
    @(posedge clk); @(negedge clk);
    req_i = noise && (rel_k != 1); data_i = 8'hEE;
    lat = -1; fl = 1'b0;
    while (n < 1000) begin
      if (done_o) begin
        lat = n; fl = full_o;
        break;
      end
      if (n + 1 == rel_k) begin
        rd_en_i = 1'b1;
        check(rd_data_o == mq[0], "R7 data under read", rd_data_o, mq[0]);
        void'(mq.pop_front());
      end
      @(posedge clk); @(negedge clk);
      rd_en_i = 1'b0;
      n++;
      req_i = noise && (n + 1 < rel_k);
    end
    req_i = 1'b0;
    if (lat >= 0 && !fl) mq.push_back(d);
  endtask

  task automatic drain(input string req);
    check(int'(level_o) == mq.size(), {req, " level"}, level_o, mq.size());
    while (!empty_o && mq.size() > 0) begin
      check(rd_data_o == mq[0], {req, " order"}, rd_data_o, mq[0]);
      void'(mq.pop_front());
      rd_en_i = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en_i = 1'b0;
    end
    check(empty_o == 1'b1, {req, " empty after drain"}, empty_o, 1);
  endtask

  task automatic fill();
    int lat; bit fl;
    while (int'(level_o) < DEPTH) begin
      do_write(8'(mq.size() + 8'h10), 0, 0, 1'b0, lat, fl);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int lat; bit fl;
    repeat (3) @(negedge clk);
    // R9 reset values
    check(done_o == 0 && full_o == 0 && busy_o == 0, "R9 reset outputs", {done_o, full_o, busy_o}, 0);
    check(empty_o == 1 && level_o == 0, "R9 reset empty", level_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: six zero-timeout writes on consecutive clocks
    for (int i = 0; i < 6; i++) begin
      req_i = 1'b1; data_i = 8'(8'h30 + i); timeout_i = 0;
      @(posedge clk); @(negedge clk);
      check(done_o == 1, "R1 done each cycle", done_o, 1);
      check(full_o == (i >= DEPTH), "R1 full flag", full_o, i >= DEPTH);
      if (i < DEPTH) mq.push_back(8'(8'h30 + i));
    end
    req_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check(done_o == 0, "R6 single pulse", done_o, 0);
    check(int'(level_o) == DEPTH, "R4 level after drops", level_o, DEPTH);

    // R3/R4: expiry latency on a full FIFO
    for (int t = 0; t <= 6; t++) begin
      do_write(8'(8'hA0 + t), t, 0, 1'b0, lat, fl);
      check(lat == t, "R3 expiry latency", lat, t);
      check(fl == 1, "R3 full reported", fl, 1);
      check(int'(level_o) == DEPTH, "R4 nothing stored", level_o, DEPTH);
    end

    // R10/R7: release at every edge inside the window
    for (int t = 1; t <= 5; t++) begin
      for (int k = 1; k <= t; k++) begin
        do_write(8'(t * 16 + k), t, k, 1'b0, lat, fl);
        check(lat == k, "R10 success latency", lat, k);
        check(fl == 0, "R7 success flag", fl, 0);
      end
    end
    drain("R8");

    // R8: read on empty ignored
    rd_en_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en_i = 1'b0;
    check(empty_o == 1 && level_o == 0, "R8 empty read ignored", level_o, 0);

    // R2: space at first edge, nonzero timeout
    do_write(8'h5A, 3, 0, 1'b0, lat, fl);
    check(lat == 0 && fl == 0, "R2 immediate push", lat, 0);
    check(rd_data_o == 8'h5A, "R2 stored data", rd_data_o, 8'h5A);
    fill();

    // R5: negative timeouts wait without limit
    for (int j = 0; j < 3; j++) begin
      int tv = (j == 0) ? -1 : (j == 1) ? -7 : 32'h8000_0000;
      do_write(8'(8'hC0 + j), tv, 25, 1'b0, lat, fl);
      check(lat == 25, "R5 unlimited wait latency", lat, 25);
      check(fl == 0, "R5 success", fl, 0);
    end

    // R6: requests while busy are ignored
    do_write(8'hD1, 10, 6, 1'b1, lat, fl);
    check(lat == 6 && fl == 0, "R6 noisy wait", lat, 6);
    @(posedge clk); @(negedge clk);
    check(done_o == 0, "R6 no extra done", done_o, 0);
    check(int'(level_o) == DEPTH, "R6 no extra store", level_o, DEPTH);
    drain("R6");

    // R9: reset during a wait
    fill();
    req_i = 1'b1; data_i = 8'hF0; timeout_i = -1;
    @(posedge clk); @(negedge clk);
    req_i = 1'b0;
    check(busy_o == 1, "R6 busy while waiting", busy_o, 1);
    rst_ni = 1'b0;
    #1;
    check(busy_o == 0 && done_o == 0 && full_o == 0, "R9 wait dropped", busy_o, 0);
    check(empty_o == 1 && level_o == 0, "R9 fifo emptied", level_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    mq.delete();
    @(negedge clk);
    check(done_o == 0 && busy_o == 0, "R9 quiet after reset", done_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule